// File: doc/BRIEF.md
# Multi-mode serial parity unit

This block is the parity section of an asynchronous serial transceiver. On the transmit side it takes the character being sent and the selected character length. It returns the parity bit that the framer appends after the last data bit, or it tells the framer that no parity bit goes out. On the receive side it takes the received character and the sampled parity bit, and it reports whether they disagree.

A three-bit mode field selects the behaviour: even, odd, forced-one (mark), forced-zero (space), or no parity. The same field also carries a multidrop code. Multidrop is handled elsewhere, so this block only suppresses parity in that mode. Data bits above the selected length (5 to 8 bits) take no part in the count.

The block holds a sticky parity-error status flag. A one-cycle receive strobe sets the flag when the character has a mismatch. The flag stays set until a reset-status command clears it.

Top module: `serial_parity_unit`

## Requirements
- R1: Mode code 000 (even): tx_par_o equals the XOR of the active data bits, so the count of ones across the data bits and the parity bit is even.
- R2: Mode code 001 (odd): tx_par_o is the inverse of the XOR of the active data bits, so the total count of ones is odd.
- R3: Mode code 011 (mark) drives tx_par_o to 1 for every character. Mode code 010 (space) drives it to 0.
- R4: Any mode code with bit 2 set gives tx_no_par_o = 1 and tx_par_o = 0. Codes 100 and 101 mean no parity, and 11x means multidrop. Codes 000 to 011 give tx_no_par_o = 0.
- R5: len_i selects the character length as 5 + len_i bits (00 = 5, 11 = 8). Data bits at positions 5 + len_i and above have no effect on tx_par_o or on rx_mismatch_o.
- R6: In even and odd modes, rx_mismatch_o is 1 when rx_par_i differs from the parity bit that R1 or R2 gives for rx_data_i. In mark mode it is 1 when rx_par_i = 0, and in space mode it is 1 when rx_par_i = 1.
- R7: With mode bit 2 set, rx_mismatch_o is 0 and par_err_o is never set.
- R8: A clock edge where rx_strobe_i = 1 and rx_mismatch_o = 1 sets par_err_o from the next cycle on. The flag then holds until it is cleared.
- R9: A clock edge with sts_clr_i = 1 clears par_err_o, unless the same edge sets it. When both happen on the same edge, the set wins.
- R10: After reset, par_err_o = 0.
- R11: A mismatch without rx_strobe_i does not set par_err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Parity mode code |
| len_i | input | 2 | Character length code, 5 + len_i bits |
| tx_data_i | input | 8 | Character being transmitted |
| tx_par_o | output | 1 | Parity bit to append |
| tx_no_par_o | output | 1 | No parity bit is sent |
| rx_data_i | input | 8 | Received character |
| rx_par_i | input | 1 | Sampled parity bit |
| rx_strobe_i | input | 1 | Character received, one cycle |
| rx_mismatch_o | output | 1 | Current received parity disagrees |
| sts_clr_i | input | 1 | Reset-status command |
| par_err_o | output | 1 | Sticky parity-error flag |

## Verification
The character with two ones is sent through all five modes, which shows that even, odd, mark and space are distinct. A character with set bits only above position 4 is tried at each length; its parity must change with length, which exposes a mask that is wrong or missing. Random characters, lengths, modes and parity bits check the transmit and receive paths against a reference count. A random strobe and clear stream, followed by directed cases (set and clear on the same edge, clear alone, mismatch without strobe, no-parity modes), separates a correct sticky flag from one that has the wrong priority or leaks.

// File: rtl/parity_pkg.sv
package parity_pkg;
  localparam int unsigned MODE_W = 3;
  typedef enum logic [2:0] {
    PK_EVEN, PK_ODD, PK_SPACE, PK_MARK, PK_NONE
  } par_kind_e;
endpackage

// File: rtl/par_mode_dec.sv
module par_mode_dec
  import parity_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output par_kind_e         kind_o
);
  // top bit set: no parity or multidrop, both suppress parity
  always_comb begin
    if (mode_i[2]) kind_o = PK_NONE;
    else begin
      unique case (mode_i[1:0])
        2'b00:   kind_o = PK_EVEN;
        2'b01:   kind_o = PK_ODD;
        2'b10:   kind_o = PK_SPACE;
        default: kind_o = PK_MARK;
      endcase
    end
  end
endmodule

// File: rtl/par_fold.sv
module par_fold #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned MIN_LEN = 5,
  localparam int unsigned LEN_W  = $clog2(DATA_W - MIN_LEN + 1)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              xor_o
);
  logic [DATA_W-1:0] keep;
  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    if (i < MIN_LEN) begin : g_fixed
      assign keep[i] = data_i[i];
    end else begin : g_opt
      assign keep[i] = data_i[i] & (32'(len_i) > 32'(i - MIN_LEN));
    end
  end
  assign xor_o = ^keep;
endmodule

// File: rtl/par_err_flag.sv
module par_err_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1; // set wins over clear
    else if (clr_i)  flag_o <= 1'b0;
  end

  assert_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
  assert_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_o);
  assert_no_spurious_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_o && !set_i) |=> !flag_o);
endmodule

// File: rtl/serial_parity_unit.sv
module serial_parity_unit
  import parity_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned MIN_LEN = 5,
  localparam int unsigned LEN_W  = $clog2(DATA_W - MIN_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        mode_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_par_o,
  output logic              tx_no_par_o,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_par_i,
  input  logic              rx_strobe_i,
  output logic              rx_mismatch_o,
  input  logic              sts_clr_i,
  output logic              par_err_o
);
  par_kind_e kind;
  logic      tx_xor, rx_xor, rx_exp;

  par_mode_dec u_dec (.mode_i(mode_i), .kind_o(kind));

  par_fold #(.DATA_W(DATA_W), .MIN_LEN(MIN_LEN)) u_tx_fold (
    .data_i(tx_data_i), .len_i(len_i), .xor_o(tx_xor));
  par_fold #(.DATA_W(DATA_W), .MIN_LEN(MIN_LEN)) u_rx_fold (
    .data_i(rx_data_i), .len_i(len_i), .xor_o(rx_xor));

  function automatic logic gen_bit(par_kind_e k, logic x);
    unique case (k)
      PK_EVEN: return x;
      PK_ODD:  return ~x;
      PK_MARK: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  always_comb begin
    tx_no_par_o   = (kind == PK_NONE);
    tx_par_o      = gen_bit(kind, tx_xor);
    rx_exp        = gen_bit(kind, rx_xor);
    rx_mismatch_o = (kind != PK_NONE) && (rx_par_i != rx_exp);
  end

  par_err_flag u_flag (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .set_i(rx_strobe_i & rx_mismatch_o),
    .clr_i(sts_clr_i), .flag_o(par_err_o));

  assert_no_par_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i[2] |-> (tx_no_par_o && !tx_par_o));
  assert_no_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i[2] |-> !rx_mismatch_o);
  assert_mark_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'b011) |-> (tx_par_o && !tx_no_par_o));
  assert_space_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'b010) |-> !tx_par_o);
endmodule

// File: tb/serial_parity_unit_tb.sv
module serial_parity_unit_tb;
  logic       clk = 0, rst_ni = 0;
  logic [2:0] mode = 0;
  logic [1:0] len = 3;
  logic [7:0] tx_data = 0, rx_data = 0;
  logic       rx_par = 0, rx_strobe = 0, sts_clr = 0;
  logic       tx_par, tx_no_par, rx_mism, par_err;
  int checks = 0, errors = 0;
  bit exp_flag = 0;
  bit done = 0;

  always #4 clk = ~clk;

  serial_parity_unit u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .len_i(len),
    .tx_data_i(tx_data), .tx_par_o(tx_par), .tx_no_par_o(tx_no_par),
    .rx_data_i(rx_data), .rx_par_i(rx_par), .rx_strobe_i(rx_strobe),
    .rx_mismatch_o(rx_mism), .sts_clr_i(sts_clr), .par_err_o(par_err));

  function automatic bit ones_par(logic [7:0] d, logic [1:0] l);
    bit p = 0;
    for (int i = 0; i < 5 + int'(l); i++) p ^= d[i];
    return p;
  endfunction
  function automatic bit ref_tx(logic [2:0] m, logic [1:0] l, logic [7:0] d);
    if (m[2]) return 0;
    case (m[1:0])
      2'b00: return ones_par(d, l);
      2'b01: return ~ones_par(d, l);
      2'b10: return 0;
      default: return 1;
    endcase
  endfunction
  function automatic bit ref_mism(logic [2:0] m, logic [1:0] l, logic [7:0] d, logic p);
    if (m[2]) return 0;
    return p != ref_tx(m, l, d);
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b (mode=%b len=%0d tx=%h rx=%h p=%b)",
               req, act, exp, mode, len, tx_data, rx_data, rx_par);
    end
  endtask

  task automatic check_comb(string req);
    #1;
    check({req, " tx_par"}, tx_par, ref_tx(mode, len, tx_data));
    check({req, " no_par"}, tx_no_par, mode[2]);
    check({req, " mismatch"}, rx_mism, ref_mism(mode, len, rx_data, rx_par));
  endtask

  // drive at negedge, model the edge, check after it
  task automatic step(logic s, logic c, string req);
    @(negedge clk);
    rx_strobe = s; sts_clr = c;
    @(posedge clk);
    if (s && ref_mism(mode, len, rx_data, rx_par)) exp_flag = 1;
    else if (c) exp_flag = 0;
    #1 check(req, par_err, exp_flag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #20;
    check("R10 reset flag", par_err, 1'b0);
    @(negedge clk); rst_ni = 1;
    #1 check("R10 after release", par_err, 1'b0);

    // 0x41 through all modes: R1 R2 R3 R4
    tx_data = 8'h41; rx_data = 8'h41; len = 3;
    for (int m = 0; m < 8; m++) begin
      @(negedge clk); mode = 3'(m); rx_par = 0;
      check_comb(m == 0 ? "R1" : m == 1 ? "R2" : m < 4 ? "R3" : "R4");
      rx_par = 1; check_comb(m < 4 ? "R6" : "R7");
    end
    @(negedge clk); mode = 3'b000;
    #1 check("R1 0x41 even", tx_par, 1'b0);
    mode = 3'b001; #1 check("R2 0x41 odd", tx_par, 1'b1);
    mode = 3'b011; #1 check("R3 0x41 mark", tx_par, 1'b1);
    mode = 3'b010; #1 check("R3 0x41 space", tx_par, 1'b0);

    // length masking R5: 0xE0 has ones at bits 5..7
    mode = 3'b000; tx_data = 8'hE0; rx_data = 8'hE0; rx_par = 0;
    for (int l = 0; l < 4; l++) begin
      @(negedge clk); len = 2'(l);
      #1 check("R5 mask tx", tx_par, 1'(l % 2));
      check("R5 mask rx", rx_mism, 1'(l % 2));
    end

    // random combinational R1 R2 R3 R4 R5 R6 R7
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      mode = 3'($urandom); len = 2'($urandom);
      tx_data = 8'($urandom); rx_data = 8'($urandom); rx_par = 1'($urandom);
      check_comb("R6 random");
    end

    // random sticky stream R8 R9 R11
    for (int n = 0; n < 400; n++) begin
      mode = 3'($urandom); len = 2'($urandom);
      rx_data = 8'($urandom); rx_par = 1'($urandom);
      step(1'($urandom % 3 == 0), 1'($urandom % 8 == 0), "R8 random sticky");
    end

    // directed sticky corners
    mode = 3'b000; len = 3; rx_data = 8'h01; rx_par = 1; // no mismatch
    step(0, 1, "R9 clear");
    check("R9 cleared", par_err, 1'b0);
    rx_par = 0; // mismatch
    step(0, 0, "R11 mismatch no strobe");
    check("R11 stays clear", par_err, 1'b0);
    step(1, 1, "R9 set beats clear");
    check("R9 set wins", par_err, 1'b1);
    rx_par = 1;
    step(1, 0, "R8 hold on good char");
    check("R8 holds", par_err, 1'b1);
    step(0, 1, "R9 clear again");
    mode = 3'b100; rx_par = 0;
    step(1, 0, "R7 none no set");
    check("R7 none flag", par_err, 1'b0);
    mode = 3'b110; rx_par = 1;
    step(1, 0, "R7 multidrop no set");
    check("R7 multidrop flag", par_err, 1'b0);
    mode = 3'b011; rx_par = 0;
    step(1, 0, "R6 mark zero sets");
    check("R6 mark error", par_err, 1'b1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule